// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Core

This block is a small synchronous static memory that takes one command per rising clock edge. A command is either a read or a write, and reads and writes can follow each other on consecutive edges with no idle cycle between them. Address, controls and byte enables are captured with the command. The write data for a command arrives later (late write). In flow-through mode it is sampled one edge after the command and read data appears one edge after the command. In pipelined mode both of these are one edge later again, because read data passes through an extra output register.

A command can open a four-beat burst. Each following advance cycle continues the burst, with the two low address bits stepping in either linear or interleaved order. A read that is issued while an earlier write to the same word has not yet reached the array gets that write's bytes forwarded to it, byte by byte. Three chip enables gate new commands. An asynchronous output enable and an asynchronous sleep input remove the read data from the outputs, and sleep also blocks new commands without disturbing the stored contents.

Top module: `lw_sram`

## Requirements
- R1: After reset, q_drv is 0 and q is all zeros until a read result is due.
- R2: With pipe_mode=0 (flow-through), a read sampled at clock edge E drives q_drv=1 with its word on q after edge E+1, for one cycle.
- R3: With pipe_mode=1 (pipelined), a read sampled at clock edge E drives q_drv=1 with its word on q after edge E+2, for one cycle.
- R4: The write data for a write command sampled at edge E is taken from d_in at edge E+1 when pipe_mode=0, and at edge E+2 when pipe_mode=1.
- R5: Reads and writes can alternate on consecutive edges. Every read returns the word as left by all writes issued before it in command order.
- R6: A write command (we_n=0) updates only the 9-bit bytes whose active-low enable bw_n[i]=0. Enable i covers d_in bits 9i+8 down to 9i.
- R7: A read issued before an earlier write to the same address has reached the array returns that write's enabled bytes. Its other bytes come from the array.
- R8: A new command is accepted only when ce1_n=0, ce2=1 and ce3_n=0 together. In any other case the cycle is a deselect: no write takes place, no read is driven, and any open burst ends.
- R9: With lin_burst=1, an advance cycle (adv=1 while a burst is open, chip enables ignored) repeats the burst's command type. Beat k (k=1..3, wrapping modulo 4) uses the start address with its two low bits replaced by (start low bits + k) mod 4.
- R10: With lin_burst=0, beat k of a burst uses the start address with its two low bits replaced by (start low bits XOR k).
- R11: While oe_n=1, q_drv is 0 and q is all zeros in that same cycle, with no clock edge needed.
- R12: While sleep=1, commands sampled are ignored and q_drv is 0. Stored words are kept and read back unchanged after sleep ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of the control and output state |
| pipe_mode | input | 1 | Static: 1 = pipelined, 0 = flow-through |
| lin_burst | input | 1 | Static: 1 = linear burst order, 0 = interleaved |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | 0 = write command, 1 = read command |
| adv | input | 1 | 1 = continue the open burst |
| addr | input | ADDR_W | Word address of a new command |
| bw_n | input | BYTES | Active-low byte write enables, one per 9-bit byte |
| d_in | input | BYTES*BYTE_W | Late write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep request, active high |
| q | output | BYTES*BYTE_W | Read data, zero when not driven |
| q_drv | output | 1 | Output drive enable for q |

## Verification
In pipelined mode, a write's array update and the evaluation of a read issued one edge later to the same word take place on the same clock edge. The read must then merge the bytes arriving on d_in with the old array contents. The bench provokes this with a full write followed at once by a one-byte write and a read to the same address, so stale, unmerged or wrongly merged data would show. The scoreboard replays commands in issue order against its own memory, so each returned word is judged against what command order demands. The other collision is a due read result meeting oe_n or sleep in its output cycle, which must then show no drive.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
  localparam int BEAT_W = 2;
  localparam int BEATS  = 1 << BEAT_W;

  // Low address bits for burst beat 'beat' starting from 'start'.
  function automatic logic [BEAT_W-1:0] beat_low(input logic [BEAT_W-1:0] start,
                                                 input logic [BEAT_W-1:0] beat,
                                                 input logic              linear);
    logic [BEAT_W-1:0] r;
    if (linear) r = start + beat;
    else        r = start ^ beat;
    return r;
  endfunction

  // All three chip enables in their active states.
  function automatic logic chips_on(input logic c1_n, input logic c2, input logic c3_n);
    return !c1_n && c2 && !c3_n;
  endfunction
endpackage

// File: rtl/lw_sram_ctrl.sv
module lw_sram_ctrl
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  logic              lin_burst,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              we_n,
  input  logic              adv,
  input  logic              sleep,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTES-1:0]  bw_n,
  output logic              wr_fire,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTES-1:0]  wr_be,
  output logic              rd_fire,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              fwd_hit
);
  // decoded command of this cycle
  logic              chip_sel, go_adv, go_new, cmd_v, cmd_we;
  logic [ADDR_W-1:0] cmd_addr;
  // burst state
  logic              b_act, b_we;
  logic [ADDR_W-1:0] b_base;
  logic [BEAT_W-1:0] b_beat, beat_nx;
  // command stages
  logic              s1_v, s1_we, s2_v, s2_we;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [BYTES-1:0]  s1_be, s2_be;

  always_comb begin
    chip_sel = chips_on(ce1_n, ce2, ce3_n);
    go_adv   = adv && b_act && !sleep;
    go_new   = !adv && chip_sel && !sleep;
    cmd_v    = go_adv || go_new;
    beat_nx  = b_beat + BEAT_W'(1);
    cmd_we   = go_adv ? b_we : !we_n;
    cmd_addr = addr;
    if (go_adv)
      cmd_addr = {b_base[ADDR_W-1:BEAT_W], beat_low(b_base[BEAT_W-1:0], beat_nx, lin_burst)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_act  <= 1'b0;
      b_we   <= 1'b0;
      b_base <= '0;
      b_beat <= '0;
    end else if (go_new) begin
      b_act  <= 1'b1;
      b_we   <= !we_n;
      b_base <= addr;
      b_beat <= '0;
    end else if (go_adv) begin
      b_beat <= beat_nx;
    end else begin
      b_act  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_we <= 1'b0; s1_addr <= '0; s1_be <= '0;
      s2_v <= 1'b0; s2_we <= 1'b0; s2_addr <= '0; s2_be <= '0;
    end else begin
      s1_v    <= cmd_v;
      s1_we   <= cmd_we;
      s1_addr <= cmd_addr;
      s1_be   <= ~bw_n;
      s2_v    <= s1_v;
      s2_we   <= s1_we;
      s2_addr <= s1_addr;
      s2_be   <= s1_be;
    end
  end

  // array update event: one stage late in flow-through, two in pipelined
  always_comb begin
    if (pipe_mode) begin
      wr_fire = s2_v && s2_we;
      wr_addr = s2_addr;
      wr_be   = s2_be;
    end else begin
      wr_fire = s1_v && s1_we;
      wr_addr = s1_addr;
      wr_be   = s1_be;
    end
    rd_fire = s1_v && !s1_we;
    rd_addr = s1_addr;
    fwd_hit = wr_fire && rd_fire && (wr_addr == rd_addr);
  end

  // R8: without all chip enables and without an advance, nothing is staged
  p_desel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_sel && !(adv && b_act)) |=> !s1_v);

  // R12: a command sampled during sleep is dropped
  p_sleep_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !s1_v);

  // R4: flow-through write reaches the array port one edge after its command
  p_late_ft_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_v && cmd_we && !pipe_mode) |=> (wr_fire && wr_addr == $past(cmd_addr)));

  // R4: pipelined write reaches the array port two edges after its command
  p_late_pl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_v && cmd_we && pipe_mode) |=> ##1 wr_fire);
endmodule

// File: rtl/lw_sram_array.sv
module lw_sram_array #(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 2,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pipe_mode,
  input  logic                    wr_fire,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [BYTES-1:0]        wr_be,
  input  logic [BYTES*BYTE_W-1:0] d_in,
  input  logic                    rd_fire,
  input  logic [ADDR_W-1:0]       rd_addr,
  input  logic                    fwd_hit,
  output logic [BYTES*BYTE_W-1:0] rd_data,
  output logic                    rd_valid
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = BYTES * BYTE_W;

  function automatic logic [BYTE_W-1:0] lane_pick(input logic              take_new,
                                                  input logic [BYTE_W-1:0] new_b,
                                                  input logic [BYTE_W-1:0] old_b);
    return take_new ? new_b : old_b;
  endfunction

  logic [DATA_W-1:0] word_rd;
  logic              r1_v, r2_v;
  logic [DATA_W-1:0] r1_d, r2_d;

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    logic [BYTE_W-1:0] mem [DEPTH];
    logic [BYTE_W-1:0] lane_old;

    always_ff @(posedge clk) begin
      if (wr_fire && wr_be[g])
        mem[wr_addr] <= d_in[g*BYTE_W +: BYTE_W];
    end

    assign lane_old = mem[rd_addr];
    assign word_rd[g*BYTE_W +: BYTE_W] =
      lane_pick(fwd_hit && wr_be[g], d_in[g*BYTE_W +: BYTE_W], lane_old);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r1_v <= 1'b0; r1_d <= '0;
      r2_v <= 1'b0; r2_d <= '0;
    end else begin
      r1_v <= rd_fire;
      r1_d <= rd_fire ? word_rd : '0;
      r2_v <= r1_v;
      r2_d <= r1_d;
    end
  end

  assign rd_valid = pipe_mode ? r2_v : r1_v;
  assign rd_data  = pipe_mode ? r2_d : r1_d;

  // R2: flow-through read result one edge after evaluation start
  p_ft_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && !pipe_mode) |=> rd_valid);

  // R2: no flow-through result without a read
  p_ft_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_fire && !pipe_mode) |=> !rd_valid);

  // R3: pipelined read result passes one more register
  p_pl_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && pipe_mode) |=> ##1 rd_valid);
endmodule

// File: rtl/lw_sram_outdrv.sv
module lw_sram_outdrv #(
  parameter int DATA_W = 18
) (
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              oe_n,
  input  logic              sleep,
  output logic [DATA_W-1:0] q,
  output logic              q_drv
);
  always_comb begin
    q_drv = rd_valid && !oe_n && !sleep;
    q     = q_drv ? rd_data : '0;
  end
endmodule

// File: rtl/lw_sram.sv
module lw_sram #(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 2,
  parameter int BYTE_W = 9,
  localparam int DATA_W = BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  logic              lin_burst,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              we_n,
  input  logic              adv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTES-1:0]  bw_n,
  input  logic [DATA_W-1:0] d_in,
  input  logic              oe_n,
  input  logic              sleep,
  output logic [DATA_W-1:0] q,
  output logic              q_drv
);
  logic              wr_fire, rd_fire, fwd_hit, rd_valid;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [BYTES-1:0]  wr_be;
  logic [DATA_W-1:0] rd_data;

  lw_sram_ctrl #(.ADDR_W(ADDR_W), .BYTES(BYTES)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .lin_burst(lin_burst),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .we_n(we_n), .adv(adv),
    .sleep(sleep), .addr(addr), .bw_n(bw_n),
    .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_be(wr_be),
    .rd_fire(rd_fire), .rd_addr(rd_addr), .fwd_hit(fwd_hit)
  );

  lw_sram_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) i_array (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode),
    .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_be(wr_be), .d_in(d_in),
    .rd_fire(rd_fire), .rd_addr(rd_addr), .fwd_hit(fwd_hit),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  lw_sram_outdrv #(.DATA_W(DATA_W)) i_outdrv (
    .rd_valid(rd_valid), .rd_data(rd_data), .oe_n(oe_n), .sleep(sleep),
    .q(q), .q_drv(q_drv)
  );
endmodule

// File: tb/test_lw_sram.sv
module test_lw_sram;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int NB = 2;
  localparam int BW = 9;
  localparam int DW = NB * BW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pipe_mode = 1'b0, lin_burst = 1'b1;
  logic          ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1, we_n = 1'b1, adv = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [NB-1:0] bw_n = '1;
  logic [DW-1:0] d_in = '0;
  logic          oe_n = 1'b0, sleep = 1'b0;
  logic [DW-1:0] q;
  logic          q_drv;

  lw_sram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(BW)) i_lw_sram (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .lin_burst(lin_burst),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .we_n(we_n), .adv(adv),
    .addr(addr), .bw_n(bw_n), .d_in(d_in), .oe_n(oe_n), .sleep(sleep),
    .q(q), .q_drv(q_drv)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int ecnt = 0;
  always @(posedge clk) ecnt <= ecnt + 1;

  int    n_cmp = 0, n_bad = 0;
  bit    done = 1'b0;
  string cur_req = "R1";
  int    lat = 1;

  // scoreboard: due edge count and expected word
  int            due_q[$];
  logic [DW-1:0] dat_q[$];

  logic [DW-1:0] model [1 << AW];
  logic [DW-1:0] dpend [4];
  logic          m_act = 1'b0, m_we = 1'b0;
  logic [AW-1:0] m_base = '0;
  int            m_beat = 0;

  task automatic check_word(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_bit(string req, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old_w, logic [DW-1:0] new_w,
                                          logic [NB-1:0] en_n);
    logic [DW-1:0] r = old_w;
    for (int b = 0; b < NB; b++)
      if (!en_n[b]) r[b*BW +: BW] = new_w[b*BW +: BW];
    return r;
  endfunction

  // burst address as the requirements define it
  function automatic logic [AW-1:0] beat_addr(logic [AW-1:0] base, int k, logic lin);
    int lo;
    logic [AW-1:0] r = base;
    if (lin) lo = (int'(base[1:0]) + k) % 4;
    else     lo = int'(base[1:0]) ^ (k % 4);
    r[1:0] = 2'(lo);
    return r;
  endfunction

  // one command cycle, called right after a falling edge
  task automatic step(logic c1n, logic c2i, logic c3n, logic wen, logic advi,
                      logic [AW-1:0] a, logic [NB-1:0] en_n, logic [DW-1:0] dat);
    int            n;
    logic          ok, go_a, go_n, valid, w;
    logic [AW-1:0] ae;
    n = ecnt;
    ce1_n = c1n; ce2 = c2i; ce3_n = c3n; we_n = wen; adv = advi;
    addr = a; bw_n = en_n;
    d_in = dpend[n % 4];
    dpend[n % 4] = '0;
    ok   = !c1n && c2i && !c3n;
    go_a = advi && m_act && !sleep;
    go_n = !advi && ok && !sleep;
    valid = go_a || go_n;
    ae = a; w = !wen;
    if (go_a) begin
      m_beat = m_beat + 1;
      ae = beat_addr(m_base, m_beat, lin_burst);
      w = m_we;
    end else if (go_n) begin
      m_act = 1'b1; m_we = !wen; m_base = a; m_beat = 0;
    end else begin
      m_act = 1'b0;
    end
    if (valid) begin
      if (w) begin
        model[ae] = merge(model[ae], dat, en_n);
        dpend[(n + lat) % 4] = dat;
      end else begin
        due_q.push_back(n + 1 + lat);
        dat_q.push_back(model[ae]);
      end
    end
    @(negedge clk);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [NB-1:0] en_n, logic [DW-1:0] dat);
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, a, en_n, dat);
  endtask
  task automatic rd(logic [AW-1:0] a);
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, a, '1, '0);
  endtask
  task automatic nop(int cnt);
    for (int i = 0; i < cnt; i++) step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, '0, '1, '0);
  endtask
  // advance with chip enables off: only an open burst gives it meaning
  task automatic advc(logic [NB-1:0] en_n, logic [DW-1:0] dat);
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, '0, en_n, dat);
  endtask

  // monitor: pops due results and judges every output cycle
  always @(negedge clk) begin
    logic [DW-1:0] exp_d;
    logic          exp_v;
    #1;
    exp_d = '0; exp_v = 1'b0;
    if (due_q.size() > 0 && due_q[0] == ecnt) begin
      exp_v = !oe_n && !sleep;
      if (exp_v) exp_d = dat_q[0];
      void'(due_q.pop_front());
      void'(dat_q.pop_front());
    end
    if (!done) begin
      check_bit(cur_req, q_drv, exp_v);
      check_word(cur_req, q, exp_d);
    end
  end

  task automatic run_mode(logic pm, logic lb);
    logic [DW-1:0] base_d;
    rst_n = 1'b0; pipe_mode = pm; lin_burst = lb; lat = pm ? 2 : 1;
    m_act = 1'b0; oe_n = 1'b0; sleep = 1'b0;
    for (int i = 0; i < 4; i++) dpend[i] = '0;
    cur_req = "R1";
    nop(3);
    rst_n = 1'b1;
    nop(1);
    check_bit("R1", q_drv, 1'b0);
    check_word("R1", q, '0);
    base_d = pm ? 18'h2A5C3 : 18'h15A3C;

    cur_req = "R4";
    for (int i = 0; i < 4; i++) wr(AW'(8 + i), '0, base_d + DW'(i * 18'h01111));
    nop(2);
    cur_req = pm ? "R3" : "R2";
    for (int i = 0; i < 4; i++) rd(AW'(8 + i));
    nop(4);

    cur_req = "R5";
    wr(6'd20, '0, 18'h0AAAA); rd(6'd8); wr(6'd21, '0, 18'h15555);
    rd(6'd20); rd(6'd21); wr(6'd8, '0, 18'h3FFFF); rd(6'd8);
    nop(4);

    cur_req = "R7";
    wr(6'd30, '0, 18'h12345); wr(6'd30, 2'b10, 18'h001FF); rd(6'd30);
    wr(6'd29, 2'b01, 18'h3FE00); rd(6'd29);
    nop(4);

    cur_req = "R6";
    wr(6'd31, '0, 18'h0F0F0); nop(1); wr(6'd31, 2'b01, 18'h3C000); nop(2); rd(6'd31);
    nop(4);

    cur_req = "R8";
    wr(6'd40, '0, 18'h0BEEF); nop(1);
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 6'd40, '0, 18'h11111);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd40, '0, 18'h22222);
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 6'd40, '0, 18'h33333);
    step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 6'd40, '1, '0);
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 6'd40, '1, '0);
    advc('0, 18'h01234);
    nop(2); rd(6'd40);
    nop(4);

    cur_req = lb ? "R9" : "R10";
    wr(6'h12, '0, 18'h10001);
    advc('0, 18'h20002); advc('0, 18'h30003); advc(2'b10, 18'h00044);
    nop(2);
    rd(6'h11); advc('1, '0); advc('1, '0); advc('1, '0); advc('1, '0);
    nop(1);
    rd(6'h13); advc('1, '0); advc('1, '0); advc('1, '0);
    nop(4);

    cur_req = "R11";
    rd(6'd8); oe_n = 1'b1; rd(6'd9); nop(2); oe_n = 1'b0; rd(6'd10); nop(3);
    oe_n = 1'b1; nop(1); oe_n = 1'b0; nop(2);

    cur_req = "R12";
    wr(6'd50, '0, 18'h0C0DE); nop(2);
    sleep = 1'b1;
    wr(6'd50, '0, 18'h3DEAD); rd(6'd50); nop(1);
    sleep = 1'b0;
    nop(2); rd(6'd50);
    rd(6'd9); sleep = 1'b1; nop(3); sleep = 1'b0; nop(3);

    cur_req = "R5";
    nop(3);
    check_bit("R5", due_q.size() == 0, 1'b1);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) model[i] = '0;
    for (int i = 0; i < 4; i++) dpend[i] = '0;
    @(negedge clk);
    // clear every word so model and array agree from the start
    rst_n = 1'b1; lat = 1; pipe_mode = 1'b0;
    for (int i = 0; i < (1 << AW); i++) wr(AW'(i), '0, '0);
    nop(3);
    run_mode(1'b0, 1'b1);
    run_mode(1'b1, 1'b0);
    run_mode(1'b1, 1'b1);
    run_mode(1'b0, 1'b0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule